// File: doc/BRIEF.md
# Window-ID Display Pixel Resolver

This block sits on the display-refresh path and resolves one pixel per clock. For each pixel it receives the stored 10-bit window code, the two image buffers (A and B), the two 4-bit overlay buffers, and one validity bit per fast-clear set. The window code is decoded in two levels. The upper field overrides the lower field whenever it is nonzero. Both fields index programmable attribute tables. The chosen attribute entry decides which image buffer is shown and how its bits are read: full 24-bit colour, compact 12-bit colour widened to 24 bits, or an 8-bit palette index. It also decides whether the overlay is opaque and which overlay buffer is used. Finally, it names the fast-clear set whose background colour replaces pixels that have not yet been drawn.

The attribute tables and the three background colours are loaded through a single-cycle register write port. Each result leaves the block exactly two clocks after its pixel was presented. A flag marks whether the result is a palette index or a direct colour. The palette and the video timing sit outside this block.

Top module: `wid_pixel_resolver`

## Requirements
- R1: The window code splits into an upper 4-bit field (bits 9:6) and a lower 6-bit field (bits 5:0). A nonzero upper field selects the upper-table entry written at address 64 + upper field. A zero upper field selects the lower-table entry written at address equal to the lower field.
- R2: Entry bit 0 picks the displayed image buffer: 0 selects `img_a` and 1 selects `img_b`.
- R3: Entry bits 2:1 pick the colour model. Code 0 passes the 24-bit image unchanged. Code 1 takes image bits 11:8, 7:4 and 3:0 as red, green and blue nibbles, and writes each nibble into both halves of its output byte, with red in bits 23:16. Code 2 outputs image bits 7:0 in `out_pix[7:0]`, with zeros above, and sets `out_is_index`. Code 3 behaves like code 0.
- R4: Entry bits 4:3 name a fast-clear set (0 = none, 1..3 = set). When the set is nonzero and `fc_valid[set-1]` is 0, the output is that set's background colour with `out_is_index` clear. Otherwise the image result stands.
- R5: Entry bit 6 marks the overlay opaque, and entry bit 5 picks the overlay buffer (0 = `ovl_a`, 1 = `ovl_b`). An opaque overlay outputs its 4-bit value in `out_pix[3:0]`, with zeros above, and sets `out_is_index`. This takes priority over both the image result and the background. A transparent overlay leaves the result untouched.
- R6: A pixel presented with `pix_valid` high at a clock edge appears with `out_valid` high after the second following edge. `out_valid` is low two clocks after a cycle with no pixel. While `out_valid` is low, `out_pix` holds its last value.
- R7: Synchronous reset clears `out_valid`, `out_pix` and `out_is_index`, and clears all three background colours.
- R8: A write with `cfg_we` high takes effect for pixels presented from the next cycle onward, and does not change a pixel presented in an earlier cycle. Background colour k (k = 1..3) lives at address 80 + k. Table entries use `cfg_data[6:0]`, and background colours use `cfg_data[23:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address (tables, background colours) |
| cfg_data | input | 24 | Configuration write data |
| pix_valid | input | 1 | A pixel is presented this cycle |
| wid | input | 10 | Stored window code of the pixel |
| img_a | input | 24 | Image buffer A data |
| img_b | input | 24 | Image buffer B data |
| ovl_a | input | 4 | Overlay buffer A value |
| ovl_b | input | 4 | Overlay buffer B value |
| fc_valid | input | 3 | Per-set fast-clear bit (1 = pixel drawn) |
| out_valid | output | 1 | Result valid |
| out_pix | output | 24 | Direct colour, or palette index in the low bits |
| out_is_index | output | 1 | 1 when `out_pix` is a palette index |

## Verification
Every lower-table code, and every nonzero upper field combined with a lower code, is presented with distinct data in each buffer. This shows whether the table that was read and the buffer that was chosen are the right ones. Targeted pixels use image values whose low 12 bits differ from their upper byte, so that pass-through, nibble widening and index extraction give visibly different results. Fast-clear patterns clear one bit at a time, to separate the named set from its neighbours. Opaque overlays are combined with an undrawn fast-clear pixel to prove the priority. Writes placed right before and right after a pixel pin down when a table change becomes visible.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // Colour model codes held in an attribute entry
  typedef enum logic [1:0] {
    CM_RGB24 = 2'd0,
    CM_RGB12 = 2'd1,
    CM_IDX8  = 2'd2,
    CM_RSVD  = 2'd3
  } cmodel_e;

  // Attribute entry, MSB first: opaque overlay, overlay buffer,
  // fast-clear set, colour model, image buffer
  typedef struct packed {
    logic       ovl_solid;
    logic       ovl_buf;
    logic [1:0] fc_set;
    cmodel_e    cmodel;
    logic       img_buf;
  } wid_entry_t;

  localparam int ENTRY_W = $bits(wid_entry_t);
  localparam int FC_SETS = 3;

endpackage

// File: rtl/wpr_lut.sv
// Synchronous-read attribute table, written so that block RAM can be inferred
module wpr_lut #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 7,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wpr_bgregs.sv
// Background colour registers, one per fast-clear set
module wpr_bgregs #(
  parameter int PIX_W   = 24,
  parameter int ADDR_W  = 7,
  parameter int NSETS   = 3,
  parameter int BG_BASE = 80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [PIX_W-1:0]       cfg_data,
  output logic [NSETS*PIX_W-1:0] bg_flat
);

  for (genvar k = 1; k <= NSETS; k++) begin : g_bg
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BG_BASE + k);
    logic [PIX_W-1:0] color;
    always_ff @(posedge clk) begin
      if (rst) color <= '0;
      else if (cfg_we && cfg_addr == SLOT) color <= cfg_data;
    end
    assign bg_flat[(k-1)*PIX_W +: PIX_W] = color;
  end

endmodule

// File: rtl/wpr_compose.sv
// Combinational pixel composition: buffer, colour model, fast clear, overlay
module wpr_compose
  import wpr_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int OVL_W = 4,
  parameter int IDX_W = 8,
  parameter int NSETS = 3,
  localparam int CH_W  = PIX_W / 3,
  localparam int NIB_W = CH_W / 2
) (
  input  wid_entry_t             entry,
  input  logic [PIX_W-1:0]       img_a,
  input  logic [PIX_W-1:0]       img_b,
  input  logic [OVL_W-1:0]       ovl_a,
  input  logic [OVL_W-1:0]       ovl_b,
  input  logic [NSETS-1:0]       fc_valid,
  input  logic [NSETS*PIX_W-1:0] bg_flat,
  output logic [PIX_W-1:0]       pix,
  output logic                   is_index
);

  logic [PIX_W-1:0] img_sel;
  logic [PIX_W-1:0] wide12;
  logic [PIX_W-1:0] model_pix;
  logic             model_idx;
  logic [PIX_W-1:0] bg_sel;
  logic             fc_hit;
  logic [OVL_W-1:0] ovl_sel;

  assign img_sel = entry.img_buf ? img_b : img_a;
  assign ovl_sel = entry.ovl_buf ? ovl_b : ovl_a;

  // Nibble replication: each compact channel fills both halves of its byte
  for (genvar c = 0; c < 3; c++) begin : g_wide
    assign wide12[c*CH_W +: CH_W] = {img_sel[c*NIB_W +: NIB_W], img_sel[c*NIB_W +: NIB_W]};
  end

  always_comb begin
    model_idx = 1'b0;
    unique case (entry.cmodel)
      CM_RGB12: model_pix = wide12;
      CM_IDX8: begin
        model_pix = {{(PIX_W-IDX_W){1'b0}}, img_sel[IDX_W-1:0]};
        model_idx = 1'b1;
      end
      default:  model_pix = img_sel;
    endcase
  end

  always_comb begin
    bg_sel = '0;
    fc_hit = 1'b0;
    for (int k = 1; k <= NSETS; k++) begin
      if (int'(entry.fc_set) == k) begin
        bg_sel = bg_flat[(k-1)*PIX_W +: PIX_W];
        fc_hit = !fc_valid[k-1];
      end
    end
  end

  always_comb begin
    if (entry.ovl_solid) begin
      pix      = {{(PIX_W-OVL_W){1'b0}}, ovl_sel};
      is_index = 1'b1;
    end else if (fc_hit) begin
      pix      = bg_sel;
      is_index = 1'b0;
    end else begin
      pix      = model_pix;
      is_index = model_idx;
    end
  end

endmodule

// File: rtl/wid_pixel_resolver.sv
module wid_pixel_resolver
  import wpr_pkg::*;
#(
  parameter int P_W    = 6,
  parameter int Q_W    = 4,
  parameter int PIX_W  = 24,
  parameter int OVL_W  = 4,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 7,
  localparam int WID_W   = P_W + Q_W,
  localparam int P_DEPTH = 1 << P_W,
  localparam int Q_DEPTH = 1 << Q_W,
  localparam int BG_BASE = P_DEPTH + Q_DEPTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [PIX_W-1:0]   cfg_data,
  input  logic               pix_valid,
  input  logic [WID_W-1:0]   wid,
  input  logic [PIX_W-1:0]   img_a,
  input  logic [PIX_W-1:0]   img_b,
  input  logic [OVL_W-1:0]   ovl_a,
  input  logic [OVL_W-1:0]   ovl_b,
  input  logic [FC_SETS-1:0] fc_valid,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix,
  output logic               out_is_index
);

  localparam logic [ADDR_W-1:0] Q_LO = ADDR_W'(P_DEPTH);
  localparam logic [ADDR_W-1:0] Q_HI = ADDR_W'(BG_BASE);

  // Configuration decode
  logic p_we, q_we;
  assign p_we = cfg_we && (cfg_addr < Q_LO);
  assign q_we = cfg_we && (cfg_addr >= Q_LO) && (cfg_addr < Q_HI);

  // Window code fields
  logic [Q_W-1:0] q_code;
  logic [P_W-1:0] p_code;
  assign q_code = wid[WID_W-1:P_W];
  assign p_code = wid[P_W-1:0];

  // Stage 1: table read and pixel data alignment
  logic [ENTRY_W-1:0] p_rd, q_rd;

  wpr_lut #(.DEPTH(P_DEPTH), .WIDTH(ENTRY_W)) u_ptab (
    .clk   (clk),
    .we    (p_we),
    .waddr (cfg_addr[P_W-1:0]),
    .wdata (cfg_data[ENTRY_W-1:0]),
    .raddr (p_code),
    .rdata (p_rd)
  );

  wpr_lut #(.DEPTH(Q_DEPTH), .WIDTH(ENTRY_W)) u_qtab (
    .clk   (clk),
    .we    (q_we),
    .waddr (cfg_addr[Q_W-1:0]),
    .wdata (cfg_data[ENTRY_W-1:0]),
    .raddr (q_code),
    .rdata (q_rd)
  );

  logic               s1_valid;
  logic               s1_qsel;
  logic [PIX_W-1:0]   s1_img_a, s1_img_b;
  logic [OVL_W-1:0]   s1_ovl_a, s1_ovl_b;
  logic [FC_SETS-1:0] s1_fc;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= pix_valid;
  end

  always_ff @(posedge clk) begin
    s1_qsel  <= (q_code != '0);
    s1_img_a <= img_a;
    s1_img_b <= img_b;
    s1_ovl_a <= ovl_a;
    s1_ovl_b <= ovl_b;
    s1_fc    <= fc_valid;
  end

  wid_entry_t s1_entry;
  assign s1_entry = wid_entry_t'(s1_qsel ? q_rd : p_rd);

  // Background colours
  logic [FC_SETS*PIX_W-1:0] bg_flat;

  wpr_bgregs #(
    .PIX_W(PIX_W), .ADDR_W(ADDR_W), .NSETS(FC_SETS), .BG_BASE(BG_BASE)
  ) u_bg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .bg_flat  (bg_flat)
  );

  // Stage 2: compose and register
  logic [PIX_W-1:0] c_pix;
  logic             c_idx;

  wpr_compose #(
    .PIX_W(PIX_W), .OVL_W(OVL_W), .IDX_W(IDX_W), .NSETS(FC_SETS)
  ) u_comp (
    .entry    (s1_entry),
    .img_a    (s1_img_a),
    .img_b    (s1_img_b),
    .ovl_a    (s1_ovl_a),
    .ovl_b    (s1_ovl_b),
    .fc_valid (s1_fc),
    .bg_flat  (bg_flat),
    .pix      (c_pix),
    .is_index (c_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pix      <= '0;
      out_is_index <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_pix      <= c_pix;
        out_is_index <= c_idx;
      end
    end
  end

endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int PIX_W = 24,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_is_index
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid); // R6

  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ##2 !out_valid); // R6

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix)); // R6

  AST_INDEX_NARROW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_index) |-> (out_pix[PIX_W-1:IDX_W] == '0)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_is_index && out_pix == '0)); // R7

endmodule

bind wid_pixel_resolver wpr_checker #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_wpr_chk (
  .clk          (clk),
  .rst          (rst),
  .pix_valid    (pix_valid),
  .out_valid    (out_valid),
  .out_pix      (out_pix),
  .out_is_index (out_is_index)
);

// File: tb/tb_wid_pixel_resolver.sv
module tb_wid_pixel_resolver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [23:0] cfg_data = '0;
  logic        pix_valid = 1'b0;
  logic [9:0]  wid = '0;
  logic [23:0] img_a = '0, img_b = '0;
  logic [3:0]  ovl_a = '0, ovl_b = '0;
  logic [2:0]  fc_valid = '0;
  logic        out_valid;
  logic [23:0] out_pix;
  logic        out_is_index;

  always #4 clk = ~clk; // 125 MHz

  wid_pixel_resolver dut (.*);

  typedef struct {
    logic [24:0] exp;
    int          stamp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [6:0]  ptab [64];
  logic [6:0]  qtab [16];
  logic [23:0] bg [4];
  logic [23:0] last_pix = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // entry: solid, ovl buffer, fast-clear set, colour model, image buffer
  function automatic logic [6:0] ent(logic s, logic ob, logic [1:0] fs, logic [1:0] cm, logic ib);
    return {s, ob, fs, cm, ib};
  endfunction

  function automatic logic [24:0] model(logic [9:0] w, logic [23:0] a, logic [23:0] b,
                                        logic [3:0] oa, logic [3:0] ob, logic [2:0] fc);
    logic [6:0]  e;
    logic [23:0] img, px;
    logic        ix;
    e   = (w[9:6] != 4'd0) ? qtab[w[9:6]] : ptab[w[5:0]];
    img = e[0] ? b : a;
    ix  = 1'b0;
    case (e[2:1])
      2'd1: px = {img[11:8], img[11:8], img[7:4], img[7:4], img[3:0], img[3:0]};
      2'd2: begin px = {16'h0, img[7:0]}; ix = 1'b1; end
      default: px = img;
    endcase
    if (e[4:3] != 2'd0 && !fc[e[4:3] - 2'd1]) begin px = bg[e[4:3]]; ix = 1'b0; end
    if (e[6]) begin px = {20'h0, e[5] ? ob : oa}; ix = 1'b1; end
    return {ix, px};
  endfunction

  task automatic cfg_write(logic [6:0] a, logic [23:0] d);
    @(negedge clk);
    pix_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    if (a < 7'd64) ptab[a[5:0]] = d[6:0];
    else if (a < 7'd80) qtab[a[3:0]] = d[6:0];
    else if (a >= 7'd81 && a <= 7'd83) bg[a - 7'd80] = d;
  endtask

  task automatic pix(logic [9:0] w, logic [23:0] a, logic [23:0] b,
                     logic [3:0] oa, logic [3:0] ob, logic [2:0] fc, string tag);
    item_t it;
    @(negedge clk);
    cfg_we = 1'b0;
    pix_valid = 1'b1; wid = w; img_a = a; img_b = b; ovl_a = oa; ovl_b = ob; fc_valid = fc;
    it.exp = model(w, a, b, oa, ob, fc);
    it.stamp = cyc;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      cfg_we = 1'b0; pix_valid = 1'b0;
    end
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R6: result with nothing pending, got %h expected none", out_pix);
        end else begin
          item_t it;
          it = sb.pop_front();
          if ({out_is_index, out_pix} !== it.exp || cyc != it.stamp + 2) begin
            fails++;
            $display("FAIL %s: got idx=%0b pix=%h at +%0d, expected idx=%0b pix=%h at +2",
                     it.tag, out_is_index, out_pix, cyc - it.stamp, it.exp[24], it.exp[23:0]);
          end
        end
        last_pix = out_pix;
      end else if (out_pix !== last_pix) begin
        checks++;
        fails++;
        $display("FAIL R6: output moved while idle, got %h expected %h", out_pix, last_pix);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) bg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_pix !== '0 || out_is_index !== 1'b0) begin
      fails++;
      $display("FAIL R7: reset state got v=%b pix=%h idx=%b expected 0/000000/0",
               out_valid, out_pix, out_is_index);
    end
    rst = 1'b0;

    // Fill tables and background colours
    for (int i = 0; i < 64; i++) cfg_write(7'(i), 24'((i * 37 + 11) & 8'h7f));
    for (int i = 0; i < 16; i++) cfg_write(7'(64 + i), 24'((i * 53 + 5) & 8'h7f));
    cfg_write(7'd81, 24'h11aa22);
    cfg_write(7'd82, 24'h33bb44);
    cfg_write(7'd83, 24'h55cc66);

    // R1: every lower code, then every nonzero upper field
    for (int i = 0; i < 64; i++)
      pix(10'(i), 24'h100000 + 24'(i * 4099), 24'h800000 + 24'(i * 7919),
          4'(i), 4'(15 - i), 3'(i), "R1");
    for (int q = 1; q < 16; q++)
      pix({4'(q), 6'(q * 3)}, 24'h0a0000 + 24'(q * 263), 24'hc00000 + 24'(q * 131),
          4'(q), 4'(q + 5), 3'(q), "R1");
    idle(3);

    // Targeted entries
    cfg_write(7'd5,  24'(ent(0, 0, 0, 2'd0, 0)));
    cfg_write(7'd6,  24'(ent(0, 0, 0, 2'd0, 1)));
    cfg_write(7'd7,  24'(ent(0, 0, 0, 2'd1, 0)));
    cfg_write(7'd8,  24'(ent(0, 0, 0, 2'd2, 1)));
    cfg_write(7'd9,  24'(ent(0, 0, 0, 2'd3, 0)));
    cfg_write(7'd10, 24'(ent(0, 0, 2'd2, 2'd0, 0)));
    cfg_write(7'd11, 24'(ent(1, 1, 0, 2'd0, 0)));
    cfg_write(7'd12, 24'(ent(1, 0, 2'd1, 2'd0, 0)));
    cfg_write(7'd13, 24'(ent(0, 1, 0, 2'd0, 1)));
    cfg_write(7'd14, 24'(ent(0, 0, 2'd1, 2'd1, 0)));
    cfg_write(7'd15, 24'(ent(0, 0, 2'd3, 2'd0, 0)));
    cfg_write(7'd67, 24'(ent(0, 0, 0, 2'd2, 0)));

    pix(10'd5, 24'h123456, 24'h654321, 4'h1, 4'h2, 3'b111, "R2");
    pix(10'd6, 24'h123456, 24'h654321, 4'h1, 4'h2, 3'b111, "R2");
    pix(10'd7, 24'hfffa5c, 24'h000000, 4'h0, 4'h0, 3'b111, "R3");
    pix(10'd8, 24'h000000, 24'h3377e1, 4'h0, 4'h0, 3'b111, "R3");
    pix(10'd9, 24'h9abcde, 24'h000000, 4'h0, 4'h0, 3'b111, "R3");
    pix({4'd3, 6'd5}, 24'habcd12, 24'h000000, 4'h0, 4'h0, 3'b111, "R1");
    pix({4'd0, 6'd5}, 24'habcd12, 24'h000000, 4'h0, 4'h0, 3'b111, "R1");
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b101, "R4");
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b010, "R4");
    pix(10'd14, 24'h000abc, 24'h0, 4'h0, 4'h0, 3'b110, "R4");
    pix(10'd14, 24'h000abc, 24'h0, 4'h0, 4'h0, 3'b001, "R4");
    pix(10'd15, 24'h246801, 24'h0, 4'h0, 4'h0, 3'b011, "R4");
    pix(10'd5,  24'h135790, 24'h0, 4'h0, 4'h0, 3'b000, "R4");
    pix(10'd11, 24'h111111, 24'h222222, 4'h3, 4'h9, 3'b111, "R5");
    pix(10'd12, 24'h111111, 24'h222222, 4'hc, 4'h9, 3'b000, "R5");
    pix(10'd13, 24'h111111, 24'h222222, 4'hf, 4'hf, 3'b111, "R5");
    idle(4);

    // R8: write then use next cycle; pixel issued before a write keeps old entry
    cfg_write(7'd5, 24'(ent(0, 0, 0, 2'd2, 0)));
    pix(10'd5, 24'h4455aa, 24'h0, 4'h0, 4'h0, 3'b111, "R8");
    cfg_write(7'd5, 24'(ent(0, 0, 0, 2'd1, 0)));
    pix(10'd5, 24'h4455aa, 24'h0, 4'h0, 4'h0, 3'b111, "R8");
    cfg_write(7'd82, 24'hdeadbe);
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b000, "R8");
    cfg_write(7'd82, 24'h010203);
    idle(2);
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b000, "R8");
    cfg_write(7'd80, 24'hffffff);
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b000, "R8");
    idle(6);

    // R7: reset clears background colours
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    for (int i = 1; i < 4; i++) bg[i] = '0;
    last_pix = '0;
    pix(10'd10, 24'h777777, 24'h0, 4'h0, 4'h0, 3'b000, "R7");
    idle(6);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d results missing, expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule